// File: doc/BRIEF.md
# Flash embedded-operation status responder

This block is the device-side status logic of a parallel NOR-style flash. When the final write strobe of a program or erase command lands, the block marks itself busy for a set number of clock cycles. It answers every read with status instead of array data while it is busy. It also pulls an open-drain ready/busy line low for that whole time.

Each read strobe inverts the toggle bit. The polling bit reports the complement of the bit being written, or zero during an erase. It switches to the true data bit one cycle before the operation completes.

A command whose target is protected still produces a busy window, only a shorter one. After that window the block returns to plain array reads. The busy length of each kind of operation is a parameter in clock cycles. The array contents arrive on `data_i` and the block passes them through while it is idle.

Top module: `flash_status_resp`

## Requirements
- R1: While not busy, `rd_data_o` equals `data_i` and `busy_od_o` is 0 (line released).
- R2: A `start_i` pulse sampled while idle makes the block busy from the next cycle. The busy time is exactly PROG_CYC cycles for an unprotected program (`op_erase_i`=0) and ERASE_CYC cycles for an unprotected erase (`op_erase_i`=1).
- R3: With `protected_i`=1 at start, the busy time is PROT_PROG_CYC cycles for a program and PROT_ERASE_CYC cycles for an erase. No data changes.
- R4: While busy, bit 6 reads 0 in the first busy cycle. It inverts in the cycle after every cycle in which a read strobe is high, and it holds otherwise.
- R5: A cycle with `oe_rd_i` high, with `ce_rd_i` high, or with both high counts as exactly one read cycle.
- R6: While idle, read strobes do not affect the data returned. The toggle bit restarts at 0 on the next operation.
- R7: While busy, except in the final busy cycle, bit 7 is the complement of bit 7 of the data captured at start for a program, and 0 for an erase.
- R8: In the final busy cycle, bit 7 equals `data_i[7]`, while bits 6..0 still carry status.
- R9: While busy, bits 5..0 read as 0.
- R10: A `start_i` pulse while busy is ignored. The busy time, the operation type and the polling value all stay unchanged.
- R11: `busy_od_o` is 1 (pulling the line low) in exactly the busy cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse at the final write strobe of a command |
| op_erase_i | input | 1 | Operation type: 0 program, 1 erase |
| protected_i | input | 1 | Target sector is protected |
| data_i | input | 8 | True array data at the read address |
| oe_rd_i | input | 1 | Read cycle by output enable |
| ce_rd_i | input | 1 | Read cycle by chip enable |
| rd_data_o | output | 8 | Data returned to the bus |
| busy_od_o | output | 1 | Open-drain pull-down enable for the ready/busy line |

## Verification
The hardest case to reach is the final busy cycle. In that cycle bit 7 already shows true data, while the toggle bit must still follow the strobe history. The bench reaches it by issuing operations with short parameterised lengths and running strobe patterns straight through to completion. The reference model therefore lines up the early switch of bit 7 against bit 6 on every cycle. A second start pulse is placed mid-operation, including in the last busy cycle, to confirm that it neither extends nor restarts the window.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;
  typedef enum logic {OP_PROG = 1'b0, OP_ERASE = 1'b1} op_e;

  function automatic int unsigned max4(int unsigned a, int unsigned b,
                                       int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/fs_dur_sel.sv
module fs_dur_sel
  import flash_stat_pkg::*;
#(
  parameter int unsigned PROG_CYC       = 500,
  parameter int unsigned ERASE_CYC      = 40000,
  parameter int unsigned PROT_PROG_CYC  = 50,
  parameter int unsigned PROT_ERASE_CYC = 5000,
  parameter int unsigned CNT_W          = 16
) (
  input  op_e              op_i,
  input  logic             prot_i,
  output logic [CNT_W-1:0] len_o
);
  always_comb begin
    unique case ({prot_i, op_i})
      {1'b0, OP_PROG}:  len_o = CNT_W'(PROG_CYC);
      {1'b0, OP_ERASE}: len_o = CNT_W'(ERASE_CYC);
      {1'b1, OP_PROG}:  len_o = CNT_W'(PROT_PROG_CYC);
      default:          len_o = CNT_W'(PROT_ERASE_CYC);
    endcase
  end
endmodule

// File: rtl/fs_op_timer.sv
module fs_op_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             busy_o,
  output logic             last_o
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= len_i - 1'b1;
      end
    end else if (cnt_q == '0) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign last_o = busy_q && (cnt_q == '0);
endmodule

// File: rtl/fs_toggle.sv
module fs_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic busy_i,
  input  logic rd_i,
  output logic tgl_o
);
  logic tgl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             tgl_q <= 1'b0;
    else if (clear_i)        tgl_q <= 1'b0;
    else if (busy_i && rd_i) tgl_q <= ~tgl_q;
  end

  assign tgl_o = tgl_q;
endmodule

// File: rtl/fs_status_mux.sv
module fs_status_mux (
  input  logic       busy_i,
  input  logic       last_i,
  input  logic       poll_i,
  input  logic       tgl_i,
  input  logic [7:0] data_i,
  output logic [7:0] rd_data_o
);
  always_comb begin
    if (!busy_i) rd_data_o = data_i;
    else         rd_data_o = {(last_i ? data_i[7] : poll_i), tgl_i, 6'b0};
  end
endmodule

// File: rtl/flash_status_resp.sv
module flash_status_resp
  import flash_stat_pkg::*;
#(
  parameter int unsigned PROG_CYC       = 500,
  parameter int unsigned ERASE_CYC      = 40000,
  parameter int unsigned PROT_PROG_CYC  = 50,
  parameter int unsigned PROT_ERASE_CYC = 5000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       op_erase_i,
  input  logic       protected_i,
  input  logic [7:0] data_i,
  input  logic       oe_rd_i,
  input  logic       ce_rd_i,
  output logic [7:0] rd_data_o,
  output logic       busy_od_o
);
  localparam int unsigned MAX_CYC = max4(PROG_CYC, ERASE_CYC, PROT_PROG_CYC, PROT_ERASE_CYC);
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1) + 1;

  op_e              op_in_w;
  op_e              op_q;
  logic             poll_q;
  logic [CNT_W-1:0] len_w;
  logic             busy_w, last_w, tgl_w, accept_w, rd_w;

  assign op_in_w  = op_e'(op_erase_i);
  assign accept_w = start_i && !busy_w;
  assign rd_w     = oe_rd_i | ce_rd_i;

  fs_dur_sel #(
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
    .PROT_PROG_CYC(PROT_PROG_CYC), .PROT_ERASE_CYC(PROT_ERASE_CYC),
    .CNT_W(CNT_W)
  ) u_dur (
    .op_i(op_in_w), .prot_i(protected_i), .len_o(len_w)
  );

  fs_op_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .len_i(len_w),
    .busy_o(busy_w), .last_o(last_w)
  );

  fs_toggle u_tgl (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(accept_w), .busy_i(busy_w),
    .rd_i(rd_w), .tgl_o(tgl_w)
  );

  // operation context latched only on an accepted start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_PROG;
      poll_q <= 1'b0;
    end else if (accept_w) begin
      op_q   <= op_in_w;
      poll_q <= (op_in_w == OP_ERASE) ? 1'b0 : ~data_i[7];
    end
  end

  fs_status_mux u_mux (
    .busy_i(busy_w), .last_i(last_w), .poll_i(poll_q), .tgl_i(tgl_w),
    .data_i(data_i), .rd_data_o(rd_data_o)
  );

  assign busy_od_o = busy_w;
endmodule

// File: rtl/fs_status_chk.sv
module fs_status_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       oe_rd_i,
  input logic       ce_rd_i,
  input logic [7:0] data_i,
  input logic [7:0] rd_data_o,
  input logic       busy_od_o,
  input logic       last_w,
  input logic       erase_q,
  input logic       poll_q
);
  AST_IDLE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_od_o |-> rd_data_o == data_i); // R1
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_od_o && start_i |=> busy_od_o); // R2
  AST_LAST_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_od_o && last_w |=> !busy_od_o); // R11
  AST_TGL_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_od_o && !last_w && (oe_rd_i || ce_rd_i) |=> rd_data_o[6] != $past(rd_data_o[6])); // R4
  AST_TGL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_od_o && !last_w && !oe_rd_i && !ce_rd_i |=> $stable(rd_data_o[6])); // R5
  AST_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_od_o |-> rd_data_o[5:0] == 6'b0); // R9
  AST_ERASE_POLL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_od_o && !last_w && erase_q |-> !rd_data_o[7]); // R7
  AST_LAST_BIT7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_od_o && last_w |-> rd_data_o[7] == data_i[7]); // R8
  AST_IGNORE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_od_o && !last_w |=> busy_od_o && $stable(erase_q) && $stable(poll_q)); // R10
endmodule

bind flash_status_resp fs_status_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .oe_rd_i(oe_rd_i),
  .ce_rd_i(ce_rd_i), .data_i(data_i), .rd_data_o(rd_data_o),
  .busy_od_o(busy_od_o), .last_w(last_w), .erase_q(op_q == flash_stat_pkg::OP_ERASE),
  .poll_q(poll_q)
);

// File: tb/sim_flash_status_resp.sv
`timescale 1ns/1ps
module sim_flash_status_resp;
  localparam int PROG = 6, ERASE = 12, PPROG = 3, PERASE = 8;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       start = 0, erase = 0, prot = 0, oe = 0, ce = 0;
  logic [7:0] data = 8'h00;
  logic [7:0] rd_data;
  logic       busy_od;

  int checks = 0, errors = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  flash_status_resp #(.PROG_CYC(PROG), .ERASE_CYC(ERASE),
                      .PROT_PROG_CYC(PPROG), .PROT_ERASE_CYC(PERASE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_erase_i(erase),
    .protected_i(prot), .data_i(data), .oe_rd_i(oe), .ce_rd_i(ce),
    .rd_data_o(rd_data), .busy_od_o(busy_od)
  );

  // behavioural reference
  bit m_busy, m_tgl, m_erase, m_d7;
  int m_rem;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_tgl = 0; m_rem = 0; m_erase = 0; m_d7 = 0;
    end else if (!m_busy) begin
      if (start) begin
        m_busy = 1; m_tgl = 0; m_erase = erase; m_d7 = data[7];
        m_rem = prot ? (erase ? PERASE : PPROG) : (erase ? ERASE : PROG);
      end
    end else begin
      if (oe || ce) m_tgl = ~m_tgl;
      m_rem--;
      if (m_rem == 0) m_busy = 0;
    end
  end

  function automatic logic [7:0] exp_data();
    if (!m_busy) return data;
    if (m_rem == 1) return {data[7], m_tgl, 6'b0};         // R8
    return {(m_erase ? 1'b0 : ~m_d7), m_tgl, 6'b0};        // R7 R9 R4
  endfunction

  task automatic check();
    logic [7:0] e;
    e = exp_data();
    checks++;
    if (rd_data !== e) begin
      errors++;
      $display("FAIL %s data: got %h exp %h at %0t", tag, rd_data, e, $time);
    end
    checks++;
    if (busy_od !== m_busy) begin
      errors++;
      $display("FAIL R11 busy: got %b exp %b at %0t", busy_od, m_busy, $time);
    end
  endtask

  task automatic cyc(input bit st, input bit er, input bit pr, input logic [7:0] d,
                     input bit o, input bit c);
    @(negedge clk);
    start = st; erase = er; prot = pr; data = d; oe = o; ce = c;
    #1 check();
  endtask

  task automatic run_op(input bit er, input bit pr, input logic [7:0] d, input int n, input int pat);
    cyc(1, er, pr, d, 0, 0);
    for (int i = 0; i < n; i++) begin
      case (pat)
        0: cyc(0, 0, 0, d ^ 8'(i), i[0], 0);
        1: cyc(0, 0, 0, d, 0, i[0]);
        2: cyc(0, 0, 0, ~d, 1, 1);
        default: cyc(0, 0, 0, d + 8'(i), i[1], i[0]);
      endcase
    end
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1 check();                 // R1 reset state
    repeat (2) @(negedge clk);
    rst_n = 1;
    tag = "R1";
    cyc(0, 0, 0, 8'hA5, 0, 0);
    cyc(0, 0, 0, 8'h3C, 1, 0);
    tag = "R6";                 // idle strobes
    cyc(0, 0, 0, 8'h5A, 1, 1);
    cyc(0, 0, 0, 8'hFF, 0, 1);
    tag = "R2 R4 R5 R7";        // program, mixed strobes
    run_op(0, 0, 8'h12, PROG + 3, 0);
    run_op(0, 0, 8'h93, PROG + 2, 1);
    tag = "R2 R7 R8";           // erase, both strobes
    run_op(1, 0, 8'h80, ERASE + 2, 2);
    run_op(1, 0, 8'h7F, ERASE + 2, 3);
    tag = "R3";                 // protected windows
    run_op(0, 1, 8'hC4, PPROG + 2, 0);
    run_op(1, 1, 8'h01, PERASE + 2, 3);
    tag = "R10";                // restart attempts while busy
    cyc(1, 0, 0, 8'h00, 0, 0);
    for (int i = 0; i < PROG - 1; i++) cyc(1, 1, i[0], 8'hFF, i[0], 0);
    cyc(1, 1, 1, 8'h80, 1, 0);  // start in final busy cycle
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 8'h44, 1, 0);
    tag = "R9 R8";
    run_op(0, 0, 8'hFF, PROG + 1, 3);
    tag = "R1";
    cyc(0, 0, 0, 8'hE7, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule